// File: doc/BRIEF.md
# Calibration Coefficient Averaging Engine

This block collects the calibration coefficients that a converter produces after each self-calibration run, sums them over several runs, and writes the rounded average back into the converter. It reaches the converter only through a plain register-access port, which has one request and one acknowledge per transaction. Coefficients sit in an indirect memory inside the converter: an index register selects a coefficient, a data register carries its value, and a control register holds separate read-enable and write-enable bits. Each transfer pass also turns the converter's calibration clock on at its start and off at its end.

A separate sequencer starts each calibration run and then issues a read-accumulate command. That command walks all 33 coefficients and adds each one into an internal 12-bit accumulator. When enough runs have been gathered, a write-average command divides every sum by a power-of-two run count, rounds the result to nearest, and writes the 33 results back. A clear strobe discards everything gathered so far. Each command ends with a one-cycle done pulse. An error flag marks a command that was refused.

Top module: `cce_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err` and `reg_req` are 0.
- R2: A read-accumulate pass makes exactly 134 transactions. It first writes 0x01 to register 0x02. Then, for each coefficient index 0 to 32 in rising order, it writes the index to 0x10, writes 0x04 to 0x0F, reads 0x11, and writes 0x00 to 0x0F. It ends by writing 0x00 to 0x02. A read transaction always targets 0x11.
- R3: A write-average pass makes exactly 70 transactions. It writes 0x01 to 0x02 and then 0x08 to 0x0F. Then, for each index 0 to 32 in rising order, it writes the index to 0x10 and the average to 0x11. It ends by writing 0x00 to 0x0F and then 0x00 to 0x02.
- R4: Each value read from 0x11 is added to the accumulator of the index last written to 0x10. With k = `run_log2`, the value written back is (sum + 2^(k-1)) >> k for k ≥ 1, or the sum itself for k = 0. The result saturates at 255.
- R5: Once `reg_req` is raised, `reg_we`, `reg_addr` and `reg_wdata` stay unchanged until the cycle in which `reg_ack` is sampled high. Each acknowledge completes exactly one transaction.
- R6: Every command that is taken ends with `done` high for exactly one cycle, whether it was accepted or refused. `err` is high only in the `done` cycle of a refused command.
- R7: A write-average command given while no run has been accumulated is refused. It makes no register transaction.
- R8: A write-average command with `run_log2` greater than 4 is refused. It makes no register transaction.
- R9: A read-accumulate command given when 16 runs have already been accumulated is refused. It makes no transaction and leaves the accumulators unchanged.
- R10: `clear` zeroes all accumulators and the run counter. When `clear` and `cmd_valid` are both high in the same idle cycle, the command is dropped.
- R11: `cmd_valid` and `clear` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_write_avg | input | 1 | 1 = write-average, 0 = read-accumulate |
| run_log2 | input | 3 | log2 of the divisor for write-average |
| clear | input | 1 | Zeroes accumulators and run counter while idle |
| busy | output | 1 | A transfer pass is in progress |
| done | output | 1 | One-cycle pulse at the end of each command |
| err | output | 1 | Command refused, high together with done |
| reg_req | output | 1 | Register transaction request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Transaction complete, one-cycle pulse |
| reg_rdata | input | 8 | Read data, valid with reg_ack |

## Verification
The converter-side model returns coefficient patterns that differ from run to run and between indices. A single run followed by k = 0 shows whether each value lands in its own accumulator, since any swap of indices or runs would show in the written data. Two runs averaged with k = 1 separate rounding to nearest from truncation, and the same sums written with k = 0 exercise the saturation at 255. Sixteen distinct runs averaged with k = 4 fill the accumulators to their widest, so they expose any carry lost at the top bit. The model also varies its acknowledge latency, which checks that request fields are held stable, and it counts every transaction against the expected order.

// File: rtl/cce_pkg.sv
package cce_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_CLK_ON  = 4'd1,
      ST_WEN_ON  = 4'd2,
      ST_ADDR    = 4'd3,
      ST_RDEN    = 4'd4,
      ST_RDATA   = 4'd5,
      ST_RDCLR   = 4'd6,
      ST_WDATA   = 4'd7,
      ST_WENOFF  = 4'd8,
      ST_CLK_OFF = 4'd9,
      ST_FIN     = 4'd10
   } cce_step_e;

endpackage

// File: rtl/cce_acc_bank.sv
module cce_acc_bank #(
   parameter int unsigned NUM_COEF = 33,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned DW       = 8,
   parameter int unsigned ACC_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [IDX_W-1:0] add_idx,
   input  logic [DW-1:0]    add_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ACC_W-1:0] rd_sum
);

   logic [ACC_W-1:0] sums [NUM_COEF];

   for (genvar g = 0; g < NUM_COEF; g++) begin : g_acc
      logic [ACC_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (clr) begin
            q <= '0;
         end else if (add_en && (add_idx == IDX_W'(g))) begin
            q <= q + ACC_W'(add_val);
         end
      end
      assign sums[g] = q;
   end

   always_comb begin
      rd_sum = '0;
      for (int i = 0; i < NUM_COEF; i++) begin
         if (rd_idx == IDX_W'(i)) rd_sum = sums[i];
      end
   end

endmodule

// File: rtl/cce_avg.sv
module cce_avg #(
   parameter int unsigned DW            = 8,
   parameter int unsigned ACC_W         = 12,
   parameter int unsigned SH_W          = 3,
   parameter bit          ROUND_NEAREST = 1'b1
) (
   input  logic [ACC_W-1:0] sum,
   input  logic [SH_W-1:0]  shift,
   output logic [DW-1:0]    avg
);

   localparam int unsigned EW = ACC_W + 1;

   logic [EW-1:0] bias;
   logic [EW-1:0] ext;
   logic [EW-1:0] shifted;

   if (ROUND_NEAREST) begin : g_round
      always_comb begin
         if (shift == '0) bias = '0;
         else             bias = EW'(1) << (shift - SH_W'(1));
      end
   end else begin : g_trunc
      assign bias = '0;
   end

   assign ext     = EW'(sum) + bias;
   assign shifted = ext >> shift;
   assign avg     = (|shifted[EW-1:DW]) ? {DW{1'b1}} : shifted[DW-1:0];

endmodule

// File: rtl/cce_walker.sv
module cce_walker
   import cce_pkg::*;
#(
   parameter int unsigned   NUM_COEF   = 33,
   parameter int unsigned   IDX_W      = 6,
   parameter int unsigned   AW         = 8,
   parameter int unsigned   DW         = 8,
   parameter logic [AW-1:0] REG_CLK    = 'h02,
   parameter logic [AW-1:0] REG_CTRL   = 'h0F,
   parameter logic [AW-1:0] REG_ADDR   = 'h10,
   parameter logic [AW-1:0] REG_DATA   = 'h11,
   parameter logic [DW-1:0] CLK_ON_VAL = 'h01,
   parameter logic [DW-1:0] RD_EN_VAL  = 'h04,
   parameter logic [DW-1:0] WR_EN_VAL  = 'h08
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             write_mode,
   input  logic             ack,
   input  logic [DW-1:0]    avg_data,
   output logic             busy,
   output logic             fin,
   output cce_step_e        step,
   output logic [IDX_W-1:0] idx,
   output logic             req,
   output logic             we,
   output logic [AW-1:0]    addr,
   output logic [DW-1:0]    wdata
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);

   cce_step_e        state_q, nxt;
   logic [IDX_W-1:0] idx_q;
   logic             wmode_q;
   logic             last;

   assign last = (idx_q == LAST_IDX);

   always_comb begin
      nxt = state_q;
      case (state_q)
         ST_CLK_ON:  nxt = wmode_q ? ST_WEN_ON : ST_ADDR;
         ST_WEN_ON:  nxt = ST_ADDR;
         ST_ADDR:    nxt = wmode_q ? ST_WDATA : ST_RDEN;
         ST_RDEN:    nxt = ST_RDATA;
         ST_RDATA:   nxt = ST_RDCLR;
         ST_RDCLR:   nxt = last ? ST_CLK_OFF : ST_ADDR;
         ST_WDATA:   nxt = last ? ST_WENOFF : ST_ADDR;
         ST_WENOFF:  nxt = ST_CLK_OFF;
         ST_CLK_OFF: nxt = ST_FIN;
         default:    nxt = state_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         wmode_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_CLK_ON;
                  idx_q   <= '0;
                  wmode_q <= write_mode;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: begin
               if (ack) begin
                  state_q <= nxt;
                  if ((state_q == ST_RDCLR || state_q == ST_WDATA) && !last)
                     idx_q <= idx_q + IDX_W'(1);
               end
            end
         endcase
      end
   end

   always_comb begin
      we    = 1'b1;
      addr  = REG_CTRL;
      wdata = '0;
      case (state_q)
         ST_CLK_ON:  begin addr = REG_CLK;  wdata = CLK_ON_VAL; end
         ST_WEN_ON:  begin addr = REG_CTRL; wdata = WR_EN_VAL;  end
         ST_ADDR:    begin addr = REG_ADDR; wdata = DW'(idx_q); end
         ST_RDEN:    begin addr = REG_CTRL; wdata = RD_EN_VAL;  end
         ST_RDATA:   begin addr = REG_DATA; we = 1'b0;          end
         ST_WDATA:   begin addr = REG_DATA; wdata = avg_data;   end
         ST_CLK_OFF: begin addr = REG_CLK;  wdata = '0;         end
         default:    begin addr = REG_CTRL; wdata = '0;         end
      endcase
   end

   assign req  = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign busy = (state_q != ST_IDLE);
   assign fin  = (state_q == ST_FIN);
   assign step = state_q;
   assign idx  = idx_q;

endmodule

// File: rtl/cce_engine.sv
module cce_engine
   import cce_pkg::*;
#(
   parameter int unsigned   NUM_COEF      = 33,
   parameter int unsigned   DW            = 8,
   parameter int unsigned   AW            = 8,
   parameter int unsigned   MAX_RUNS_LOG2 = 4,
   parameter bit            ROUND_NEAREST = 1'b1,
   parameter logic [AW-1:0] REG_CLK       = 'h02,
   parameter logic [AW-1:0] REG_CTRL      = 'h0F,
   parameter logic [AW-1:0] REG_ADDR      = 'h10,
   parameter logic [AW-1:0] REG_DATA      = 'h11,
   parameter logic [DW-1:0] CLK_ON_VAL    = 'h01,
   parameter logic [DW-1:0] RD_EN_VAL     = 'h04,
   parameter logic [DW-1:0] WR_EN_VAL     = 'h08,
   localparam int unsigned  RL_W          = $clog2(MAX_RUNS_LOG2 + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic            cmd_write_avg,
   input  logic [RL_W-1:0] run_log2,
   input  logic            clear,
   output logic            busy,
   output logic            done,
   output logic            err,
   output logic            reg_req,
   output logic            reg_we,
   output logic [AW-1:0]   reg_addr,
   output logic [DW-1:0]   reg_wdata,
   input  logic            reg_ack,
   input  logic [DW-1:0]   reg_rdata
);

   localparam int unsigned IDX_W    = $clog2(NUM_COEF);
   localparam int unsigned ACC_W    = DW + MAX_RUNS_LOG2;
   localparam int unsigned MAX_RUNS = 2 ** MAX_RUNS_LOG2;
   localparam int unsigned RUN_W    = MAX_RUNS_LOG2 + 1;

   if (NUM_COEF < 2) begin : g_bad_num
      $error("cce_engine: NUM_COEF must be at least 2");
   end
   if (IDX_W >= DW) begin : g_bad_idx
      $error("cce_engine: coefficient index must fit the data width");
   end
   if (MAX_RUNS_LOG2 < 1) begin : g_bad_runs
      $error("cce_engine: MAX_RUNS_LOG2 must be at least 1");
   end

   cce_step_e        step;
   logic [IDX_W-1:0] idx;
   logic             fin;
   logic             walk_busy;
   logic [ACC_W-1:0] cur_sum;
   logic [DW-1:0]    cur_avg;

   logic [RUN_W-1:0] runs_q;
   logic [RL_W-1:0]  shift_q;
   logic             mode_q;
   logic             done_q, err_q;

   logic idle, take_clr, take_cmd, reject, start, add_en;

   assign idle     = !walk_busy;
   assign take_clr = idle && clear;
   assign take_cmd = idle && !clear && cmd_valid;
   assign reject   = take_cmd &&
                     (cmd_write_avg ? ((runs_q == '0) || (run_log2 > RL_W'(MAX_RUNS_LOG2)))
                                    : (runs_q == RUN_W'(MAX_RUNS)));
   assign start    = take_cmd && !reject;
   assign add_en   = (step == ST_RDATA) && reg_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         runs_q  <= '0;
         shift_q <= '0;
         mode_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= fin || reject;
         err_q  <= reject;
         if (start) begin
            shift_q <= run_log2;
            mode_q  <= cmd_write_avg;
         end
         if (take_clr) begin
            runs_q <= '0;
         end else if (fin && !mode_q) begin
            runs_q <= runs_q + RUN_W'(1);
         end
      end
   end

   cce_walker #(
      .NUM_COEF  (NUM_COEF),
      .IDX_W     (IDX_W),
      .AW        (AW),
      .DW        (DW),
      .REG_CLK   (REG_CLK),
      .REG_CTRL  (REG_CTRL),
      .REG_ADDR  (REG_ADDR),
      .REG_DATA  (REG_DATA),
      .CLK_ON_VAL(CLK_ON_VAL),
      .RD_EN_VAL (RD_EN_VAL),
      .WR_EN_VAL (WR_EN_VAL)
   ) i_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .write_mode(cmd_write_avg),
      .ack       (reg_ack),
      .avg_data  (cur_avg),
      .busy      (walk_busy),
      .fin       (fin),
      .step      (step),
      .idx       (idx),
      .req       (reg_req),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata)
   );

   cce_acc_bank #(
      .NUM_COEF(NUM_COEF),
      .IDX_W   (IDX_W),
      .DW      (DW),
      .ACC_W   (ACC_W)
   ) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (take_clr),
      .add_en (add_en),
      .add_idx(idx),
      .add_val(reg_rdata),
      .rd_idx (idx),
      .rd_sum (cur_sum)
   );

   cce_avg #(
      .DW           (DW),
      .ACC_W        (ACC_W),
      .SH_W         (RL_W),
      .ROUND_NEAREST(ROUND_NEAREST)
   ) i_avg (
      .sum  (cur_sum),
      .shift(shift_q),
      .avg  (cur_avg)
   );

   assign busy = walk_busy;
   assign done = done_q;
   assign err  = err_q;

endmodule

// File: rtl/cce_engine_chk.sv
module cce_engine_chk #(
   parameter int unsigned   NUM_COEF = 33,
   parameter int unsigned   AW       = 8,
   parameter int unsigned   DW       = 8,
   parameter logic [AW-1:0] REG_CTRL = 'h0F,
   parameter logic [AW-1:0] REG_ADDR = 'h10,
   parameter logic [AW-1:0] REG_DATA = 'h11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_req,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic          reg_ack,
   input logic          busy,
   input logic          done,
   input logic          err
);

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata));

   a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !reg_req);

   a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r2_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_ack && !reg_we |=> reg_req && reg_we && (reg_addr == REG_CTRL) && (reg_wdata == '0));

   a_r2_read_target: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_we |-> reg_addr == REG_DATA);

   a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_we && (reg_addr == REG_ADDR) |-> reg_wdata < DW'(NUM_COEF));

endmodule

bind cce_engine cce_engine_chk #(
   .NUM_COEF(NUM_COEF),
   .AW      (AW),
   .DW      (DW),
   .REG_CTRL(REG_CTRL),
   .REG_ADDR(REG_ADDR),
   .REG_DATA(REG_DATA)
) i_cce_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_req  (reg_req),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_ack  (reg_ack),
   .busy     (busy),
   .done     (done),
   .err      (err)
);

// File: tb/test_cce_engine.sv
module test_cce_engine;

   localparam int NC = 33;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_write_avg = 1'b0;
   logic [2:0] run_log2 = '0;
   logic       clear = 1'b0;
   logic       busy, done, err;
   logic       reg_req, reg_we;
   logic [7:0] reg_addr, reg_wdata;
   logic       reg_ack;
   logic [7:0] reg_rdata;

   always #10 clk = ~clk;

   cce_engine i_cce_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write_avg(cmd_write_avg),
      .run_log2(run_log2), .clear(clear), .busy(busy), .done(done), .err(err),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_ack(reg_ack), .reg_rdata(reg_rdata)
   );

   int checks = 0;
   int failures = 0;
   int dev_mem [NC];
   int wr_mem [NC];
   int sum_m [NC];
   int m_clk = 0, m_ctrl = 0, m_addr = 0;
   int txn_idx = 0, seq_err = 0, hold_err = 0;
   bit pass_wr = 1'b0;
   bit pend = 1'b0;
   int wcnt = 0;
   logic [16:0] cap;
   logic [17:0] exp_e;

   function automatic logic [17:0] exp_txn(bit wr, int j);
      int m, i;
      if (!wr) begin
         if (j == 0)   return {1'b0, 1'b1, 8'h02, 8'h01};
         if (j == 133) return {1'b0, 1'b1, 8'h02, 8'h00};
         m = j - 1; i = m / 4;
         case (m % 4)
            0:       return {1'b0, 1'b1, 8'h10, 8'(i)};
            1:       return {1'b0, 1'b1, 8'h0F, 8'h04};
            2:       return {1'b0, 1'b0, 8'h11, 8'h00};
            default: return {1'b0, 1'b1, 8'h0F, 8'h00};
         endcase
      end else begin
         if (j == 0)  return {1'b0, 1'b1, 8'h02, 8'h01};
         if (j == 1)  return {1'b0, 1'b1, 8'h0F, 8'h08};
         if (j == 68) return {1'b0, 1'b1, 8'h0F, 8'h00};
         if (j == 69) return {1'b0, 1'b1, 8'h02, 8'h00};
         m = j - 2; i = m / 2;
         if (m % 2 == 0) return {1'b0, 1'b1, 8'h10, 8'(i)};
         return {1'b1, 1'b1, 8'h11, 8'h00};
      end
   endfunction

   // converter register model with varying acknowledge latency
   always @(posedge clk) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_rdata <= '0;
         pend = 1'b0;
      end else if (reg_ack) begin
         reg_ack <= 1'b0;
      end else if (reg_req) begin
         if (!pend) begin
            pend = 1'b1;
            cap  = {reg_we, reg_addr, reg_wdata};
            wcnt = 0;
         end else if (cap !== {reg_we, reg_addr, reg_wdata}) begin
            hold_err++;
         end
         if (wcnt < (txn_idx % 3)) begin
            wcnt++;
         end else begin
            pend = 1'b0;
            reg_ack <= 1'b1;
            if (txn_idx >= (pass_wr ? 70 : 134)) begin
               seq_err++;
            end else begin
               exp_e = exp_txn(pass_wr, txn_idx);
               if (reg_we !== exp_e[16] || reg_addr !== exp_e[15:8] ||
                   (!exp_e[17] && reg_we && reg_wdata !== exp_e[7:0]))
                  seq_err++;
            end
            txn_idx++;
            if (reg_we) begin
               case (reg_addr)
                  8'h02: m_clk  = int'(reg_wdata);
                  8'h0F: m_ctrl = int'(reg_wdata);
                  8'h10: m_addr = int'(reg_wdata);
                  8'h11: begin
                     if (m_ctrl == 8 && m_clk == 1 && m_addr < NC) wr_mem[m_addr] = int'(reg_wdata);
                     else seq_err++;
                  end
                  default: seq_err++;
               endcase
            end else begin
               if (m_ctrl == 4 && m_clk == 1 && m_addr < NC) reg_rdata <= 8'(dev_mem[m_addr]);
               else begin seq_err++; reg_rdata <= '0; end
            end
         end
      end
   end

   task automatic chk(bit ok, string rq, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
      end
   endtask

   function automatic int pat(int p, int i);
      return (p * 37 + i * 11 + p * i * 5) % 256;
   endfunction

   function automatic int avg_exp(int s, int k);
      int v;
      v = (k == 0) ? s : ((s + (1 << (k - 1))) >> k);
      return (v > 255) ? 255 : v;
   endfunction

   task automatic run_cmd(bit wr, int k, bit inject, output bit got_err, output int ntx);
      int waitc;
      pass_wr = wr; txn_idx = 0; seq_err = 0; hold_err = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write_avg = wr; run_log2 = 3'(k);
      @(negedge clk);
      cmd_valid = 1'b0;
      waitc = 0;
      while (!done && waitc < 4000) begin
         if (inject && waitc == 20) begin
            clear = 1'b1; cmd_valid = 1'b1; cmd_write_avg = !wr;
         end
         @(negedge clk);
         clear = 1'b0; cmd_valid = 1'b0;
         waitc++;
      end
      got_err = err;
      ntx = txn_idx;
      chk(done, "R6", "done pulse seen", int'(done), 1);
      chk(hold_err == 0, "R5", "request fields changed before ack", hold_err, 0);
      @(negedge clk);
      chk(!done, "R6", "done lasts one cycle", int'(done), 0);
   endtask

   task automatic do_accum(int p, bit expect_ok, bit inject);
      bit e; int n;
      for (int i = 0; i < NC; i++) dev_mem[i] = pat(p, i);
      run_cmd(1'b0, 0, inject, e, n);
      if (expect_ok) begin
         chk(!e, "R2", "accumulate refused", int'(e), 0);
         chk(n == 134, "R2", "read pass transaction count", n, 134);
         chk(seq_err == 0, "R2", "read pass order errors", seq_err, 0);
         for (int i = 0; i < NC; i++) sum_m[i] += dev_mem[i];
      end else begin
         chk(e, "R9", "accumulate past limit not refused", int'(e), 1);
         chk(n == 0, "R9", "refused accumulate transactions", n, 0);
      end
   endtask

   task automatic do_write(int k, bit expect_ok, string rq);
      bit e; int n;
      for (int i = 0; i < NC; i++) wr_mem[i] = -1;
      run_cmd(1'b1, k, 1'b0, e, n);
      if (expect_ok) begin
         chk(!e, "R3", "write-average refused", int'(e), 0);
         chk(n == 70, "R3", "write pass transaction count", n, 70);
         chk(seq_err == 0, "R3", "write pass order errors", seq_err, 0);
         for (int i = 0; i < NC; i++)
            chk(wr_mem[i] == avg_exp(sum_m[i], k), rq, $sformatf("average idx %0d k %0d", i, k),
                wr_mem[i], avg_exp(sum_m[i], k));
      end else begin
         chk(e, rq, "write-average not refused", int'(e), 1);
         chk(n == 0, rq, "refused write transactions", n, 0);
      end
   endtask

   initial begin
      for (int i = 0; i < NC; i++) begin sum_m[i] = 0; wr_mem[i] = -1; dev_mem[i] = 0; end
      @(negedge clk);
      chk(!busy && !done && !err && !reg_req, "R1", "outputs during reset",
          int'({busy, done, err, reg_req}), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !reg_req, "R1", "outputs after reset",
          int'({busy, done, err, reg_req}), 0);

      do_write(0, 1'b0, "R7");

      do_accum(1, 1'b1, 1'b0);
      do_write(0, 1'b1, "R4");
      do_write(5, 1'b0, "R8");
      do_accum(2, 1'b1, 1'b0);
      do_write(1, 1'b1, "R4");
      do_write(0, 1'b1, "R4");

      // R10: clear and command together, clear wins
      txn_idx = 0;
      @(negedge clk);
      clear = 1'b1; cmd_valid = 1'b1; cmd_write_avg = 1'b0;
      @(negedge clk);
      clear = 1'b0; cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      chk(!busy && txn_idx == 0, "R10", "command taken alongside clear", txn_idx, 0);
      for (int i = 0; i < NC; i++) sum_m[i] = 0;
      do_write(0, 1'b0, "R10");

      // R11: clear and command injected mid-pass are ignored
      do_accum(3, 1'b1, 1'b1);
      repeat (10) @(negedge clk);
      chk(txn_idx == 134, "R11", "extra traffic after injected command", txn_idx, 134);
      do_write(0, 1'b1, "R11");

      for (int p = 4; p <= 18; p++) do_accum(p, 1'b1, 1'b0);
      do_write(4, 1'b1, "R4");
      do_accum(19, 1'b0, 1'b0);
      do_write(4, 1'b1, "R9");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule